// File: doc/BRIEF.md
# Indexed Vector Load/Store Address Sequencer

This block turns one register-plus-register indexed load or store into a stream of per-element effective addresses. A start pulse captures the vector length, the vector/scalar flags of the base register, the index register, the destination and the update register, and the two predicate masks. It also captures the index element width, the signed-index flag and the fail-first request. The block then walks separate element counters for base, index, destination and update. Each counter skips the elements its predicate disables. Base and index values come from two indexed register read ports.

Each element leaves as a valid/ready request. The request carries the effective address, the destination element number and an optional update write of the address to the update register at its own element number. A one-cycle done pulse closes the operation. When fail-first is requested with a vector base or index, the block does not probe independent addresses. It issues an element-strided sequence from the scalar base and index instead. Memory access and vector-length truncation are handled elsewhere.

Top module: `lvx_idx_seq`

## Requirements
- R1: After reset, `req_valid` and `done` are 0.
- R2: In normal mode the request address is the value read at register `ra_num+i` plus the widened value read at register `rb_num+k`. The base element counter i is used only when `ra_vec`=1 and the index element counter k only when `rb_vec`=1; otherwise the counter stays 0.
- R3: A vector base or index counter moves to the next element whose `src_mask` bit is 1, where bit n of the mask belongs to element n. A vector destination counter moves to the next element whose `dst_mask` bit is 1. `req_dst_elem` reports the destination counter.
- R4: Issue continues only while every active counter is below `vl`. `done` is high for exactly one cycle, in the cycle after the last accepted request. If no element qualifies, `done` is high in the cycle after the start edge and no request is made.
- R5: With `rt_vec`=0, exactly one request is issued.
- R6: With `ra_vec`=0 and `rb_vec`=0 and no rewrite in effect, exactly one request is issued.
- R7: `rb_ew` selects the index width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits, taken from the low bits of the read value. With `sea`=1 the narrow value is sign-extended to 64 bits; with `sea`=0 it is zero-extended.
- R8: With `ffirst`=1 and either `ra_vec` or `rb_vec` set, both reads use element 0 (registers `ra_num` and `rb_num`). Element i, counting 0,1,2,… without mask skipping, gets the address base + i × widened index. With both flags scalar, `ffirst` has no effect.
- R9: `req_upd_we` equals `upd_en` on each request. With `upd_en` and `upd_vec` set, `req_upd_elem` walks `src_mask` like R3 and must also stay below `vl`. Otherwise it stays 0.
- R10: While `req_valid`=1 and `req_ready`=0, the request is held unchanged in the next cycle.
- R11: A start pulse while an operation is in progress is ignored, including any register numbers presented with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| vl | input | IW | Vector length, 0 to VL_MAX |
| ra_vec | input | 1 | Base register is a vector |
| rb_vec | input | 1 | Index register is a vector |
| rt_vec | input | 1 | Destination is a vector |
| upd_en | input | 1 | Write each address back to the update register |
| upd_vec | input | 1 | Update register is a vector |
| src_mask | input | VL_MAX | Source predicate, bit n for element n |
| dst_mask | input | VL_MAX | Destination predicate, bit n for element n |
| rb_ew | input | 2 | Index element width code |
| sea | input | 1 | Sign-extend a narrow index |
| ffirst | input | 1 | Fail-first requested |
| ra_num | input | REG_W | Base register number |
| rb_num | input | REG_W | Index register number |
| ra_rd_reg | output | REG_W | Base read port register select |
| ra_rd_data | input | 64 | Base read port data (same cycle) |
| rb_rd_reg | output | REG_W | Index read port register select |
| rb_rd_data | input | 64 | Index read port data (same cycle) |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Request accepted when high with valid |
| req_addr | output | 64 | Effective address |
| req_dst_elem | output | IW | Destination element number |
| req_upd_we | output | 1 | Update write requested |
| req_upd_elem | output | IW | Update register element number |
| done | output | 1 | Operation finished (one cycle) |

## Verification
The bench sweeps every combination of the vector flags and fail-first against several mask pairs, vector lengths including zero and the maximum, all four index widths and both sign modes, under random backpressure. Masks with gaps and disjoint source and destination patterns check that each counter skips on its own. A design that shared one counter, or used the wrong mask, would emit wrong addresses or wrong destination numbers. An empty destination mask, or a zero vector length, must give a bare done. A design that checked the range only after issuing would emit a spurious request. The index value is chosen so that narrow widths have the sign bit set. A missing or wrong extension would then produce addresses off by a multiple of 2^8, 2^16 or 2^32. A fail-first operation whose rewrite is omitted reads vector registers instead of base + i × index, and the bench detects the wrong addresses. Start pulses with altered register numbers mid-run expose a design that restarts or re-captures.

// File: rtl/lvx_pkg.sv
package lvx_pkg;

    localparam int unsigned LVX_XLEN = 64;

    localparam int LANE_RA  = 0;
    localparam int LANE_RB  = 1;
    localparam int LANE_RT  = 2;
    localparam int LANE_UP  = 3;
    localparam int N_LANES  = 4;

    typedef enum logic [1:0] {
        EW_B8  = 2'd0,
        EW_B16 = 2'd1,
        EW_B32 = 2'd2,
        EW_B64 = 2'd3
    } ew_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    // Widen the low bits of an index register to full width.
    function automatic logic [LVX_XLEN-1:0] widen_index(
        input logic [LVX_XLEN-1:0] raw,
        input ew_e                 ew,
        input logic                signed_ea
    );
        logic [LVX_XLEN-1:0] r;
        case (ew)
            EW_B8:   r = signed_ea ? {{(LVX_XLEN-8){raw[7]}}, raw[7:0]}
                                   : {{(LVX_XLEN-8){1'b0}}, raw[7:0]};
            EW_B16:  r = signed_ea ? {{(LVX_XLEN-16){raw[15]}}, raw[15:0]}
                                   : {{(LVX_XLEN-16){1'b0}}, raw[15:0]};
            EW_B32:  r = signed_ea ? {{(LVX_XLEN-32){raw[31]}}, raw[31:0]}
                                   : {{(LVX_XLEN-32){1'b0}}, raw[31:0]};
            default: r = raw;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lvx_lane_walker.sv
module lvx_lane_walker #(
    parameter int VL_MAX = 8,
    parameter int IW     = $clog2(VL_MAX + 1)
) (
    input  logic [VL_MAX-1:0] mask,
    input  logic [IW-1:0]     cur,
    input  logic              inc,
    input  logic              skip,
    output logic [IW-1:0]     nxt
);
    logic [IW-1:0] cand;

    always_comb begin
        cand = cur + IW'(inc);
        if (skip) begin
            // lowest enabled element at or above the candidate, else VL_MAX
            nxt = IW'(VL_MAX);
            for (int p = VL_MAX - 1; p >= 0; p--) begin
                if ((IW'(p) >= cand) && mask[p]) begin
                    nxt = IW'(p);
                end
            end
        end else begin
            nxt = cand;
        end
    end
endmodule

// File: rtl/lvx_ea_unit.sv
module lvx_ea_unit
    import lvx_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic [LVX_XLEN-1:0] base_val,
    input  logic [LVX_XLEN-1:0] index_raw,
    input  ew_e                 ew,
    input  logic                signed_ea,
    input  logic                strided,
    input  logic [IW-1:0]       elem,
    output logic [LVX_XLEN-1:0] ea
);
    logic [LVX_XLEN-1:0] idx_w;
    logic [LVX_XLEN-1:0] scaled;

    always_comb begin
        idx_w  = widen_index(index_raw, ew, signed_ea);
        scaled = idx_w * {{(LVX_XLEN-IW){1'b0}}, elem};
        ea     = base_val + (strided ? scaled : idx_w);
    end
endmodule

// File: rtl/lvx_idx_seq.sv
module lvx_idx_seq
    import lvx_pkg::*;
#(
    parameter int VL_MAX = 8,
    parameter int REG_W  = 7,
    localparam int IW    = $clog2(VL_MAX + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [IW-1:0]       vl,
    input  logic                ra_vec,
    input  logic                rb_vec,
    input  logic                rt_vec,
    input  logic                upd_en,
    input  logic                upd_vec,
    input  logic [VL_MAX-1:0]   src_mask,
    input  logic [VL_MAX-1:0]   dst_mask,
    input  logic [1:0]          rb_ew,
    input  logic                sea,
    input  logic                ffirst,
    input  logic [REG_W-1:0]    ra_num,
    input  logic [REG_W-1:0]    rb_num,
    output logic [REG_W-1:0]    ra_rd_reg,
    input  logic [LVX_XLEN-1:0] ra_rd_data,
    output logic [REG_W-1:0]    rb_rd_reg,
    input  logic [LVX_XLEN-1:0] rb_rd_data,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [LVX_XLEN-1:0] req_addr,
    output logic [IW-1:0]       req_dst_elem,
    output logic                req_upd_we,
    output logic [IW-1:0]       req_upd_elem,
    output logic                done
);
    typedef struct packed {
        logic [IW-1:0]     vl;
        logic              ra_vec;
        logic              rb_vec;
        logic              rt_vec;
        logic              upd_en;
        logic              upd_vec;
        logic [VL_MAX-1:0] src_mask;
        logic [VL_MAX-1:0] dst_mask;
        ew_e               ew;
        logic              sea;
        logic              strided;
        logic [REG_W-1:0]  ra_num;
        logic [REG_W-1:0]  rb_num;
    } cfg_t;

    seq_state_e state_q;
    cfg_t       cfg_q, cfg_in, cfg_use;
    logic       done_q;
    logic       running;
    logic       all_ok;
    logic       stop_one;
    logic       take;

    logic [IW-1:0]     idx_q    [N_LANES];
    logic [IW-1:0]     idx_nxt  [N_LANES];
    logic [IW-1:0]     lane_cur [N_LANES];
    logic [VL_MAX-1:0] lane_mask[N_LANES];
    logic [N_LANES-1:0] lane_skip, lane_inc, lane_rng, lane_ok;

    always_comb begin
        cfg_in.vl       = vl;
        cfg_in.ra_vec   = ra_vec;
        cfg_in.rb_vec   = rb_vec;
        cfg_in.rt_vec   = rt_vec;
        cfg_in.upd_en   = upd_en;
        cfg_in.upd_vec  = upd_vec;
        cfg_in.src_mask = src_mask;
        cfg_in.dst_mask = dst_mask;
        cfg_in.ew       = ew_e'(rb_ew);
        cfg_in.sea      = sea;
        cfg_in.strided  = ffirst && (ra_vec || rb_vec);
        cfg_in.ra_num   = ra_num;
        cfg_in.rb_num   = rb_num;
    end

    assign running = (state_q == ST_RUN);
    assign cfg_use = running ? cfg_q : cfg_in;

    // Per-lane stepping rules: base, index, destination, update.
    always_comb begin
        lane_mask[LANE_RA] = cfg_use.src_mask;
        lane_mask[LANE_RB] = cfg_use.src_mask;
        lane_mask[LANE_RT] = cfg_use.dst_mask;
        lane_mask[LANE_UP] = cfg_use.src_mask;

        lane_skip[LANE_RA] = cfg_use.ra_vec && !cfg_use.strided;
        lane_skip[LANE_RB] = cfg_use.rb_vec && !cfg_use.strided;
        lane_skip[LANE_RT] = cfg_use.rt_vec;
        lane_skip[LANE_UP] = cfg_use.upd_en && cfg_use.upd_vec;

        lane_inc[LANE_RA]  = running && (cfg_use.ra_vec || cfg_use.strided);
        lane_inc[LANE_RB]  = running && cfg_use.rb_vec && !cfg_use.strided;
        lane_inc[LANE_RT]  = running && cfg_use.rt_vec;
        lane_inc[LANE_UP]  = running && cfg_use.upd_en && cfg_use.upd_vec;

        lane_rng[LANE_RA]  = 1'b1;
        lane_rng[LANE_RB]  = 1'b1;
        lane_rng[LANE_RT]  = 1'b1;
        lane_rng[LANE_UP]  = cfg_use.upd_en && cfg_use.upd_vec;
    end

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        assign lane_cur[g] = running ? idx_q[g] : '0;

        lvx_lane_walker #(
            .VL_MAX (VL_MAX),
            .IW     (IW)
        ) u_walk (
            .mask (lane_mask[g]),
            .cur  (lane_cur[g]),
            .inc  (lane_inc[g]),
            .skip (lane_skip[g]),
            .nxt  (idx_nxt[g])
        );

        assign lane_ok[g] = !lane_rng[g] || (idx_nxt[g] < cfg_use.vl);
    end

    assign all_ok   = &lane_ok;
    assign stop_one = !cfg_q.rt_vec ||
                      (!cfg_q.strided && !cfg_q.ra_vec && !cfg_q.rb_vec);
    assign take     = running && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            done_q  <= 1'b0;
            for (int l = 0; l < N_LANES; l++) begin
                idx_q[l] <= '0;
            end
        end else begin
            done_q <= 1'b0;
            if (!running) begin
                if (start) begin
                    cfg_q <= cfg_in;
                    for (int l = 0; l < N_LANES; l++) begin
                        idx_q[l] <= idx_nxt[l];
                    end
                    if (all_ok) begin
                        state_q <= ST_RUN;
                    end else begin
                        done_q <= 1'b1;
                    end
                end
            end else if (take) begin
                if (stop_one || !all_ok) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end else begin
                    for (int l = 0; l < N_LANES; l++) begin
                        idx_q[l] <= idx_nxt[l];
                    end
                end
            end
        end
    end

    // Register read selects.
    always_comb begin
        ra_rd_reg = cfg_q.ra_num;
        rb_rd_reg = cfg_q.rb_num;
        if (cfg_q.ra_vec && !cfg_q.strided) begin
            ra_rd_reg = cfg_q.ra_num + REG_W'(idx_q[LANE_RA]);
        end
        if (cfg_q.rb_vec && !cfg_q.strided) begin
            rb_rd_reg = cfg_q.rb_num + REG_W'(idx_q[LANE_RB]);
        end
    end

    lvx_ea_unit #(
        .IW (IW)
    ) u_ea (
        .base_val  (ra_rd_data),
        .index_raw (rb_rd_data),
        .ew        (cfg_q.ew),
        .signed_ea (cfg_q.sea),
        .strided   (cfg_q.strided),
        .elem      (idx_q[LANE_RA]),
        .ea        (req_addr)
    );

    assign req_valid    = running;
    assign req_dst_elem = idx_q[LANE_RT];
    assign req_upd_elem = idx_q[LANE_UP];
    assign req_upd_we   = running && cfg_q.upd_en;
    assign done         = done_q;
endmodule

// File: rtl/lvx_idx_seq_chk.sv
module lvx_idx_seq_chk #(
    parameter int VL_MAX = 8,
    parameter int IW     = 4,
    parameter int REG_W  = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [IW-1:0]     req_dst_elem,
    input logic [REG_W-1:0]  ra_rd_reg,
    input logic              done,
    input logic [IW-1:0]     vl_q,
    input logic              rt_vec_q,
    input logic [VL_MAX-1:0] dst_mask_q
);
    a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_dst_elem) && $stable(ra_rd_reg));

    a_r4_done_without_request: assert property (@(posedge clk) disable iff (rst)
        done |-> !req_valid);

    a_r4_dest_below_length: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_dst_elem < vl_q));

    a_r3_dest_enabled: assert property (@(posedge clk) disable iff (rst)
        req_valid && rt_vec_q |-> dst_mask_q[req_dst_elem[$clog2(VL_MAX)-1:0]]);

    a_r5_scalar_dest_single: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && !rt_vec_q |=> done && !req_valid);
endmodule

bind lvx_idx_seq lvx_idx_seq_chk #(
    .VL_MAX (VL_MAX),
    .IW     (IW),
    .REG_W  (REG_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_dst_elem (req_dst_elem),
    .ra_rd_reg    (ra_rd_reg),
    .done         (done),
    .vl_q         (cfg_q.vl),
    .rt_vec_q     (cfg_q.rt_vec),
    .dst_mask_q   (cfg_q.dst_mask)
);

// File: tb/tb_lvx_idx_seq.sv
module tb_lvx_idx_seq;
    localparam int VL_MAX = 8;
    localparam int REG_W  = 7;
    localparam int IW     = $clog2(VL_MAX + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [IW-1:0] vl = '0;
    logic ra_vec = 0, rb_vec = 0, rt_vec = 0, upd_en = 0, upd_vec = 0;
    logic [VL_MAX-1:0] src_mask = '0, dst_mask = '0;
    logic [1:0] rb_ew = '0;
    logic sea = 0, ffirst = 0;
    logic [REG_W-1:0] ra_num = '0, rb_num = '0;
    logic [REG_W-1:0] ra_rd_reg, rb_rd_reg;
    logic [63:0] ra_rd_data, rb_rd_data;
    logic req_valid, req_upd_we, done;
    logic req_ready = 1'b0;
    logic [63:0] req_addr;
    logic [IW-1:0] req_dst_elem, req_upd_elem;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    logic [15:0] lf = 16'hACE1;

    logic [63:0] exp_addr [VL_MAX];
    int exp_j [VL_MAX];
    int exp_u [VL_MAX];
    int exp_n;

    always #2 clk = ~clk;

    lvx_idx_seq #(.VL_MAX(VL_MAX), .REG_W(REG_W)) dut (
        .clk(clk), .rst(rst), .start(start), .vl(vl),
        .ra_vec(ra_vec), .rb_vec(rb_vec), .rt_vec(rt_vec),
        .upd_en(upd_en), .upd_vec(upd_vec),
        .src_mask(src_mask), .dst_mask(dst_mask),
        .rb_ew(rb_ew), .sea(sea), .ffirst(ffirst),
        .ra_num(ra_num), .rb_num(rb_num),
        .ra_rd_reg(ra_rd_reg), .ra_rd_data(ra_rd_data),
        .rb_rd_reg(rb_rd_reg), .rb_rd_data(rb_rd_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_dst_elem(req_dst_elem), .req_upd_we(req_upd_we),
        .req_upd_elem(req_upd_elem), .done(done)
    );

    function automatic logic [63:0] regval(input logic [REG_W-1:0] r);
        return 64'h9E37_79B9_7F4A_7C15 * ({57'd0, r} + 64'd1);
    endfunction

    assign ra_rd_data = regval(ra_rd_reg);
    assign rb_rd_data = regval(rb_rd_reg);

    // R7: code 0/1/2/3 -> 8/16/32/64 bits, sign or zero fill
    function automatic logic [63:0] widen(input logic [63:0] v, input logic [1:0] c, input logic s);
        int bits;
        logic [63:0] m;
        bits = (c == 2'd0) ? 8 : (c == 2'd1) ? 16 : (c == 2'd2) ? 32 : 64;
        if (bits == 64) return v;
        m = (64'd1 << bits) - 64'd1;
        if (s && v[bits-1]) return (v & m) | ~m;
        return v & m;
    endfunction

    function automatic int next_on(input logic [VL_MAX-1:0] m, input int from);
        int p = from;
        while (p < VL_MAX && !m[p]) p++;
        return p;
    endfunction

    task automatic build_expected();
        int i = 0, j = 0, k = 0, u = 0;
        logic strided;
        logic [63:0] rbv;
        strided = ffirst && (ra_vec || rb_vec);
        exp_n = 0;
        forever begin
            if (ra_vec && !strided) i = next_on(src_mask, i);
            if (rb_vec && !strided) k = next_on(src_mask, k);
            if (rt_vec) j = next_on(dst_mask, j);
            if (upd_en && upd_vec) u = next_on(src_mask, u);
            if (i >= vl || j >= vl || k >= vl || (upd_en && upd_vec && u >= vl)) break;
            if (strided) begin
                rbv = widen(regval(rb_num), rb_ew, sea);
                exp_addr[exp_n] = regval(ra_num) + rbv * 64'(i);
            end else begin
                rbv = widen(regval(rb_num + REG_W'(k)), rb_ew, sea);
                exp_addr[exp_n] = regval(ra_num + REG_W'(i)) + rbv;
            end
            exp_j[exp_n] = j;
            exp_u[exp_n] = u;
            exp_n++;
            if (!rt_vec) break;
            if (!strided && !ra_vec && !rb_vec) break;
            if (ra_vec || strided) i++;
            if (rb_vec && !strided) k++;
            j++;
            if (upd_en && upd_vec) u++;
        end
    endtask

    task automatic fail(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        errors++;
        $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    endtask

    task automatic run_op(input bit stress);
        int n = 0;
        bit finished = 0, want_done, stalled = 0;
        logic [63:0] prev_addr = '0;
        logic [REG_W-1:0] base_ra;
        string tag, ctag;
        base_ra = ra_num;
        build_expected();
        tag  = (ffirst && (ra_vec || rb_vec)) ? "R8" : (rb_ew != 2'd3) ? "R7" : "R2";
        ctag = !rt_vec ? "R5" : (!ra_vec && !rb_vec && !ffirst) ? "R6" : "R4";
        want_done = (exp_n == 0);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int it = 0; it < 80 && !finished; it++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            req_ready = (lf[1:0] != 2'b00);
            if (stress && it == 1 && req_valid) begin
                start  = 1'b1;   // R11: must be ignored
                ra_num = base_ra ^ 7'h55;
            end else begin
                start  = 1'b0;
                ra_num = base_ra;
            end
            #1;
            if (stalled) begin
                checks++;
                if (!req_valid || req_addr !== prev_addr)
                    fail("R10", "held request", {63'd0, req_valid} ^ req_addr, prev_addr);
            end
            if (done) begin
                checks++;
                if (n != exp_n || req_valid) fail(ctag, "count at done", 64'(n), 64'(exp_n));
                finished = 1;
            end else if (want_done) begin
                checks++;
                fail("R4", "done pulse missing", {63'd0, done}, 64'd1);
                finished = 1;
            end else if (req_valid) begin
                if (n >= exp_n) begin
                    checks++;
                    fail(ctag, "extra request", 64'(n), 64'(exp_n));
                    finished = 1;
                end else if (req_ready) begin
                    checks++;
                    if (req_addr !== exp_addr[n]) fail(tag, "address", req_addr, exp_addr[n]);
                    else if (req_dst_elem !== IW'(exp_j[n]))
                        fail("R3", "dest element", 64'(req_dst_elem), 64'(exp_j[n]));
                    else if (req_upd_we !== upd_en || req_upd_elem !== IW'(exp_u[n]))
                        fail("R9", "update", {req_upd_we, 59'd0, req_upd_elem}, {upd_en, 59'd0, IW'(exp_u[n])});
                    n++;
                    if (n == exp_n) want_done = 1;
                end
            end
            stalled   = req_valid && !req_ready && !done;
            prev_addr = req_addr;
            @(negedge clk);
        end
        req_ready = 1'b0;
        start     = 1'b0;
        ra_num    = base_ra;
        if (!finished) begin
            checks++;
            fail("R4", "operation never finished", 64'(n), 64'(exp_n));
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<190000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [VL_MAX-1:0] sm [4];
        logic [VL_MAX-1:0] dm [4];
        int vls [3];
        int opn = 0;
        sm[0] = 8'hFF; dm[0] = 8'hFF;
        sm[1] = 8'hA5; dm[1] = 8'h3C;
        sm[2] = 8'hF0; dm[2] = 8'h00;
        sm[3] = 8'h5A; dm[3] = 8'hD3;
        vls[0] = 0; vls[1] = 3; vls[2] = VL_MAX;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        checks++;
        if (req_valid !== 1'b0) fail("R1", "valid after reset", {63'd0, req_valid}, 64'd0);
        checks++;
        if (done !== 1'b0) fail("R1", "done after reset", {63'd0, done}, 64'd0);
        for (int f = 0; f < 32; f++) begin
            for (int mi = 0; mi < 4; mi++) begin
                for (int vi = 0; vi < 3; vi++) begin
                    for (int e = 0; e < 8; e++) begin
                        ra_vec   = f[0];
                        rb_vec   = f[1];
                        rt_vec   = f[2];
                        upd_vec  = f[3];
                        ffirst   = f[4];
                        upd_en   = mi[0] | f[3];
                        src_mask = sm[mi];
                        dst_mask = dm[mi];
                        vl       = IW'(vls[vi]);
                        rb_ew    = e[1:0];
                        sea      = e[2];
                        ra_num   = REG_W'(f + 3);
                        rb_num   = REG_W'(40 + 2 * f + mi);
                        run_op((opn % 5) == 0);
                        opn++;
                    end
                end
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule